// File: doc/BRIEF.md
# Fault Classification and Escalation Unit

This block sits beside a processor core's exception logic. It receives one-cycle strobes from the bus and memory-protection paths whenever an access fails. These include a vector fetch, a hardware context save or restore, a data access, an instruction address check and an instruction fetch. Each failure is sorted into one of three handler classes: hard fault, memory-management fault or bus fault. The block records a sticky cause bit for each failure and queues an exception request for the class that will handle it.

A memory-management or bus fault is only taken when its class is enabled and its handler priority is strictly more urgent than the current execution priority. Otherwise the fault is escalated to the hard-fault class and a forced-escalation bit is recorded. Supervisor-call and breakpoint events that cannot be taken at their own priority are escalated in the same way. Instruction-fetch bus errors are held back. They fault only when the fetched instruction executes, and they vanish without trace when the fetch is flushed. Priorities are unsigned, and a lower number is more urgent. The hard-fault class sits above every configurable value and is never escalated further.

The exception request is registered and stays on the outputs until acknowledged. Classes that arrive together are presented one after another, most urgent first. Software clears the status fields by writing ones.

Top module: `flt_escalate_top`

## Requirements
- R1: After reset, all status fields read zero and `req_valid` is low.
- R2: `ev_vec_err` sets `st_hard[0]` and always raises a hard-fault request. It never sets the forced bit `st_hard[1]` on its own.
- R3: Context-save and context-restore failures are recorded in their own bits. A bus error during save sets `st_bus[3]`, and one during restore sets `st_bus[2]`; both route to the bus class. A protection violation during save sets `st_mem[3]`, and one during restore sets `st_mem[2]`; both route to the memory-management class.
- R4: A data-access protection violation sets `st_mem[0]` and an instruction-address violation sets `st_mem[1]`, both routing to the memory-management class. A precise data bus error sets `st_bus[0]` and routes to the bus class.
- R5: `ev_fetch_bus` only marks a fetch error as pending and changes no output. A later `instr_exec` with no `instr_flush` in the same cycle sets `st_bus[1]` and raises a bus-class fault. `instr_flush` discards the pending error with no status change, and it wins over `instr_exec` in the same cycle.
- R6: A configurable fault is taken in its own class only when three conditions hold: its enable is high, `hard_active` is low, and its priority is numerically lower than `cur_prio`. Otherwise a hard-fault request is raised and `st_hard[1]` is set. The cause bit is set in either case.
- R7: `ev_svc` with `prio_svc >= cur_prio` or `hard_active` high escalates to hard fault and sets `st_hard[1]`. `ev_bkpt` does the same when `mon_en` is low, `prio_mon >= cur_prio` or `hard_active` is high. When either event can be taken, no request or status results.
- R8: Events arriving in the same cycle set all of their status bits. Their classes are presented one per acknowledge, in the order hard, memory-management, bus.
- R9: The request appears in the cycle after its event. `req_class` encodes 1 for hard, 2 for memory-management and 3 for bus, and is never 0 while `req_valid` is high. Valid and class stay unchanged until `req_ack`. The next pending class, if any, is presented in the cycle after the acknowledge.
- R10: When `clr_we` is high, `clr_sel` picks a status field (0 hard, 1 memory-management, 2 bus; 3 selects nothing) and each one in `clr_mask` clears that bit. A bit being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_vec_err | input | 1 | Bus error on vector read |
| ev_save_bus | input | 1 | Bus error during context save |
| ev_save_mpu | input | 1 | Protection violation during context save |
| ev_rest_bus | input | 1 | Bus error during context restore |
| ev_rest_mpu | input | 1 | Protection violation during context restore |
| ev_data_mpu | input | 1 | Protection violation on data access |
| ev_inst_mpu | input | 1 | Protection violation on instruction address |
| ev_data_bus | input | 1 | Precise data bus error |
| ev_fetch_bus | input | 1 | Instruction-fetch bus error (held pending) |
| instr_exec | input | 1 | Fetched instruction reaches execute |
| instr_flush | input | 1 | Fetched instruction is flushed |
| ev_svc | input | 1 | Supervisor call |
| ev_bkpt | input | 1 | Breakpoint |
| en_mem | input | 1 | Memory-management class enable |
| en_bus | input | 1 | Bus class enable |
| mon_en | input | 1 | Breakpoint monitor enable |
| prio_mem | input | PRIO_W | Memory-management handler priority |
| prio_bus | input | PRIO_W | Bus handler priority |
| prio_svc | input | PRIO_W | Supervisor-call priority |
| prio_mon | input | PRIO_W | Breakpoint monitor priority |
| cur_prio | input | PRIO_W | Current execution priority |
| hard_active | input | 1 | Core is running at hard-fault priority |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_sel | input | 2 | Status field selector |
| clr_mask | input | 4 | Bits to clear |
| req_valid | output | 1 | Exception request pending |
| req_class | output | 2 | Requested class |
| req_ack | input | 1 | Request accepted |
| st_hard | output | 2 | Hard status: [0] vector read, [1] forced |
| st_mem | output | 4 | Memory-management cause bits |
| st_bus | output | 4 | Bus cause bits |

## Verification
The hardest situations to reach from the ports involve timing rather than values. One is a fetch error that must stay invisible through idle cycles and then either fault on execute or disappear on flush. The other is a stack of pending classes that must drain in a fixed order while the presented class holds still. The bench reaches the first by pulsing the fetch strobe and then separately driving idle, execute, flush, and execute-with-flush cycles, checking the status between each step. It reaches the second by raising three classes in one cycle and walking the queue with acknowledges. It also raises a hard fault while a memory-management request is held unacknowledged. Escalation is swept over every configurable cause, both enable values, the three priority relations and both values of `hard_active`.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HARD = 2'd1,
    CLS_MEM  = 2'd2,
    CLS_BUS  = 2'd3
  } flt_cls_e;

  localparam int HARD_W   = 2;
  localparam int MEM_W    = 4;
  localparam int BUS_W    = 4;
  localparam int CLS_N    = 3;
  localparam int PRIO_MAX = 16;

  // pending index: 0 hard, 1 mem, 2 bus
  localparam int PI_HARD = 0;
  localparam int PI_MEM  = 1;
  localparam int PI_BUS  = 2;

  // a handler runs only if enabled, not under hard fault, and strictly more urgent
  function automatic logic can_take(input logic en, input logic in_hard,
                                    input logic [PRIO_MAX-1:0] prio,
                                    input logic [PRIO_MAX-1:0] cur);
    return en && !in_hard && (prio < cur);
  endfunction

  function automatic flt_cls_e pick_class(input logic [CLS_N-1:0] pend);
    if (pend[PI_HARD])     return CLS_HARD;
    else if (pend[PI_MEM]) return CLS_MEM;
    else if (pend[PI_BUS]) return CLS_BUS;
    else                   return CLS_NONE;
  endfunction

  function automatic logic [CLS_N-1:0] class_bit(input flt_cls_e c);
    case (c)
      CLS_HARD: return 3'b001;
      CLS_MEM:  return 3'b010;
      CLS_BUS:  return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/flt_fetch_hold.sv
module flt_fetch_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_fetch_bus,
  input  logic instr_exec,
  input  logic instr_flush,
  output logic fetch_fire
);
  logic pend_q;

  assign fetch_fire = pend_q && instr_exec && !instr_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend_q <= 1'b0;
    else if (ev_fetch_bus)            pend_q <= 1'b1;
    else if (instr_flush || instr_exec) pend_q <= 1'b0;
  end
endmodule

// File: rtl/flt_route.sv
module flt_route
  import flt_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              ev_vec_err,
  input  logic              ev_save_bus,
  input  logic              ev_save_mpu,
  input  logic              ev_rest_bus,
  input  logic              ev_rest_mpu,
  input  logic              ev_data_mpu,
  input  logic              ev_inst_mpu,
  input  logic              ev_data_bus,
  input  logic              fetch_fire,
  input  logic              ev_svc,
  input  logic              ev_bkpt,
  input  logic              en_mem,
  input  logic              en_bus,
  input  logic              mon_en,
  input  logic [PRIO_W-1:0] prio_mem,
  input  logic [PRIO_W-1:0] prio_bus,
  input  logic [PRIO_W-1:0] prio_svc,
  input  logic [PRIO_W-1:0] prio_mon,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              hard_active,
  output logic [HARD_W-1:0] set_hard,
  output logic [MEM_W-1:0]  set_mem,
  output logic [BUS_W-1:0]  set_bus,
  output logic [CLS_N-1:0]  raise,
  output logic              forced
);
  logic mem_any, bus_any, mem_ok, bus_ok, svc_ok, bkpt_ok;

  assign set_mem = {ev_save_mpu, ev_rest_mpu, ev_inst_mpu, ev_data_mpu};
  assign set_bus = {ev_save_bus, ev_rest_bus, fetch_fire, ev_data_bus};
  assign mem_any = |set_mem;
  assign bus_any = |set_bus;

  assign mem_ok  = can_take(en_mem, hard_active, PRIO_MAX'(prio_mem), PRIO_MAX'(cur_prio));
  assign bus_ok  = can_take(en_bus, hard_active, PRIO_MAX'(prio_bus), PRIO_MAX'(cur_prio));
  assign svc_ok  = can_take(1'b1,   hard_active, PRIO_MAX'(prio_svc), PRIO_MAX'(cur_prio));
  assign bkpt_ok = can_take(mon_en, hard_active, PRIO_MAX'(prio_mon), PRIO_MAX'(cur_prio));

  assign forced = (mem_any && !mem_ok) || (bus_any && !bus_ok) ||
                  (ev_svc && !svc_ok) || (ev_bkpt && !bkpt_ok);

  assign set_hard        = {forced, ev_vec_err};
  assign raise[PI_HARD]  = ev_vec_err || forced;
  assign raise[PI_MEM]   = mem_any && mem_ok;
  assign raise[PI_BUS]   = bus_any && bus_ok;
endmodule

// File: rtl/flt_sticky.sv
module flt_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set,
  output logic [W-1:0] st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~(clr_en ? clr_mask : '0)) | set;
  end
endmodule

// File: rtl/flt_req.sv
module flt_req
  import flt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_N-1:0] raise,
  input  logic             ack,
  output logic             req_valid,
  output flt_cls_e         req_class
);
  logic [CLS_N-1:0] pend_q, pend_n, retire;
  logic             ack_take, load;

  assign ack_take = ack && req_valid;
  assign retire   = ack_take ? class_bit(req_class) : '0;
  assign pend_n   = (pend_q & ~retire) | raise;
  assign load     = !req_valid || ack_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      req_valid <= 1'b0;
      req_class <= CLS_NONE;
    end else begin
      pend_q <= pend_n;
      if (load) begin
        req_valid <= |pend_n;
        req_class <= pick_class(pend_n);
      end
    end
  end
endmodule

// File: rtl/flt_escalate_top.sv
module flt_escalate_top
  import flt_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_vec_err,
  input  logic              ev_save_bus,
  input  logic              ev_save_mpu,
  input  logic              ev_rest_bus,
  input  logic              ev_rest_mpu,
  input  logic              ev_data_mpu,
  input  logic              ev_inst_mpu,
  input  logic              ev_data_bus,
  input  logic              ev_fetch_bus,
  input  logic              instr_exec,
  input  logic              instr_flush,
  input  logic              ev_svc,
  input  logic              ev_bkpt,
  input  logic              en_mem,
  input  logic              en_bus,
  input  logic              mon_en,
  input  logic [PRIO_W-1:0] prio_mem,
  input  logic [PRIO_W-1:0] prio_bus,
  input  logic [PRIO_W-1:0] prio_svc,
  input  logic [PRIO_W-1:0] prio_mon,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              hard_active,
  input  logic              clr_we,
  input  logic [1:0]        clr_sel,
  input  logic [3:0]        clr_mask,
  output logic              req_valid,
  output logic [1:0]        req_class,
  input  logic              req_ack,
  output logic [HARD_W-1:0] st_hard,
  output logic [MEM_W-1:0]  st_mem,
  output logic [BUS_W-1:0]  st_bus
);
  // named internal events, observed by the checker
  logic              fetch_fire;
  logic [HARD_W-1:0] set_hard;
  logic [MEM_W-1:0]  set_mem;
  logic [BUS_W-1:0]  set_bus;
  logic [CLS_N-1:0]  raise_vec;
  logic              forced;
  logic [CLS_N-1:0]  clr_field;
  flt_cls_e          cls_q;

  flt_fetch_hold u_fetch (
    .clk(clk), .rst_n(rst_n), .ev_fetch_bus(ev_fetch_bus),
    .instr_exec(instr_exec), .instr_flush(instr_flush), .fetch_fire(fetch_fire)
  );

  flt_route #(.PRIO_W(PRIO_W)) u_route (
    .ev_vec_err(ev_vec_err), .ev_save_bus(ev_save_bus), .ev_save_mpu(ev_save_mpu),
    .ev_rest_bus(ev_rest_bus), .ev_rest_mpu(ev_rest_mpu), .ev_data_mpu(ev_data_mpu),
    .ev_inst_mpu(ev_inst_mpu), .ev_data_bus(ev_data_bus), .fetch_fire(fetch_fire),
    .ev_svc(ev_svc), .ev_bkpt(ev_bkpt), .en_mem(en_mem), .en_bus(en_bus),
    .mon_en(mon_en), .prio_mem(prio_mem), .prio_bus(prio_bus), .prio_svc(prio_svc),
    .prio_mon(prio_mon), .cur_prio(cur_prio), .hard_active(hard_active),
    .set_hard(set_hard), .set_mem(set_mem), .set_bus(set_bus),
    .raise(raise_vec), .forced(forced)
  );

  // one field selected per write: 0 hard, 1 mem, 2 bus
  genvar gi;
  generate
    for (gi = 0; gi < CLS_N; gi++) begin : g_sel
      assign clr_field[gi] = clr_we && (clr_sel == 2'(gi));
    end
  endgenerate

  flt_sticky #(.W(HARD_W)) u_st_hard (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_field[PI_HARD]),
    .clr_mask(clr_mask[HARD_W-1:0]), .set(set_hard), .st(st_hard)
  );
  flt_sticky #(.W(MEM_W)) u_st_mem (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_field[PI_MEM]),
    .clr_mask(clr_mask[MEM_W-1:0]), .set(set_mem), .st(st_mem)
  );
  flt_sticky #(.W(BUS_W)) u_st_bus (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_field[PI_BUS]),
    .clr_mask(clr_mask[BUS_W-1:0]), .set(set_bus), .st(st_bus)
  );

  flt_req u_req (
    .clk(clk), .rst_n(rst_n), .raise(raise_vec), .ack(req_ack),
    .req_valid(req_valid), .req_class(cls_q)
  );
  assign req_class = cls_q;
endmodule

// File: rtl/flt_escalate_chk.sv
module flt_escalate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ack,
  input logic       req_valid,
  input logic [1:0] req_class,
  input logic       ev_vec_err,
  input logic       ev_data_bus,
  input logic       en_bus,
  input logic       instr_exec,
  input logic [1:0] st_hard,
  input logic [3:0] st_bus,
  input logic [2:0] raise_vec
);
  p_vec_hard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_err |=> st_hard[0]);

  p_fetch_needs_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_bus[1]) |-> $past(instr_exec));

  p_disabled_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_bus && !en_bus) |=> st_hard[1]);

  p_hard_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vec[0] && (!req_valid || req_ack)) |=> (req_valid && req_class == 2'd1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_class)));

  p_class_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_class != 2'd0);
endmodule

bind flt_escalate_top flt_escalate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_valid(req_valid),
  .req_class(req_class), .ev_vec_err(ev_vec_err), .ev_data_bus(ev_data_bus),
  .en_bus(en_bus), .instr_exec(instr_exec), .st_hard(st_hard), .st_bus(st_bus),
  .raise_vec(raise_vec)
);

// File: tb/flt_escalate_top_bench.sv
module flt_escalate_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_vec_err = 0, ev_save_bus = 0, ev_save_mpu = 0, ev_rest_bus = 0, ev_rest_mpu = 0;
  logic ev_data_mpu = 0, ev_inst_mpu = 0, ev_data_bus = 0, ev_fetch_bus = 0;
  logic instr_exec = 0, instr_flush = 0, ev_svc = 0, ev_bkpt = 0;
  logic en_mem = 1, en_bus = 1, mon_en = 1, hard_active = 0;
  logic [7:0] prio_mem = 8'h10, prio_bus = 8'h10, prio_svc = 8'h10, prio_mon = 8'h10;
  logic [7:0] cur_prio = 8'h40;
  logic clr_we = 0;
  logic [1:0] clr_sel = 0;
  logic [3:0] clr_mask = 0;
  logic req_valid, req_ack = 0;
  logic [1:0] req_class;
  logic [1:0] st_hard;
  logic [3:0] st_mem, st_bus;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flt_escalate_top u_flt_escalate_top (
    .clk(clk), .rst_n(rst_n), .ev_vec_err(ev_vec_err), .ev_save_bus(ev_save_bus),
    .ev_save_mpu(ev_save_mpu), .ev_rest_bus(ev_rest_bus), .ev_rest_mpu(ev_rest_mpu),
    .ev_data_mpu(ev_data_mpu), .ev_inst_mpu(ev_inst_mpu), .ev_data_bus(ev_data_bus),
    .ev_fetch_bus(ev_fetch_bus), .instr_exec(instr_exec), .instr_flush(instr_flush),
    .ev_svc(ev_svc), .ev_bkpt(ev_bkpt), .en_mem(en_mem), .en_bus(en_bus),
    .mon_en(mon_en), .prio_mem(prio_mem), .prio_bus(prio_bus), .prio_svc(prio_svc),
    .prio_mon(prio_mon), .cur_prio(cur_prio), .hard_active(hard_active),
    .clr_we(clr_we), .clr_sel(clr_sel), .clr_mask(clr_mask), .req_valid(req_valid),
    .req_class(req_class), .req_ack(req_ack), .st_hard(st_hard), .st_mem(st_mem),
    .st_bus(st_bus)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // request as one number: 0 when idle, else class code
  function automatic int req_now();
    return req_valid ? int'(req_class) : 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_ev(input int e, input logic v);
    case (e)
      0: ev_save_bus = v;
      1: ev_save_mpu = v;
      2: ev_rest_bus = v;
      3: ev_rest_mpu = v;
      4: ev_data_mpu = v;
      5: ev_inst_mpu = v;
      default: ev_data_bus = v;
    endcase
  endtask

  task automatic clear_all();
    for (int s = 0; s < 3; s++) begin
      clr_we = 1; clr_sel = 2'(s); clr_mask = 4'hF;
      tick();
    end
    clr_we = 0; clr_mask = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) begin
      if (req_valid) begin
        req_ack = 1; tick(); req_ack = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 st_hard", st_hard, 0);
    check("R1 st_mem", st_mem, 0);
    check("R1 st_bus", st_bus, 0);
    check("R1 req", req_now(), 0);
    rst_n = 1;
    tick();

    // R2 vector read error
    ev_vec_err = 1; tick(); ev_vec_err = 0;
    check("R2 st_hard", st_hard, 1);
    check("R2 req", req_now(), 1);
    drain(); clear_all();

    // R3 R4 R6 sweep: cause x enable x priority relation x hard_active
    for (int e = 0; e < 7; e++)
      for (int en = 0; en < 2; en++)
        for (int r = 0; r < 3; r++)
          for (int h = 0; h < 2; h++) begin
            bit is_mem, take;
            int bitpos, exp_cls;
            is_mem = (e == 1) || (e == 3) || (e == 4) || (e == 5);
            bitpos = (e == 0 || e == 1) ? 3 : (e == 2 || e == 3) ? 2 : (e == 5) ? 1 : 0;
            take = (en == 1) && (h == 0) && (r == 0);
            exp_cls = take ? (is_mem ? 2 : 3) : 1;
            en_mem = 1'(en); en_bus = 1'(en);
            prio_mem = 8'h3F + 8'(r); prio_bus = 8'h3F + 8'(r);
            hard_active = 1'(h);
            set_ev(e, 1); tick(); set_ev(e, 0);
            check(is_mem ? "R3/R4 mem cause" : "R3/R4 bus cause",
                  is_mem ? st_mem : st_bus, 1 << bitpos);
            check("R6 other field", is_mem ? st_bus : st_mem, 0);
            check("R6 forced", st_hard, take ? 0 : 2);
            check("R6 class", req_now(), exp_cls);
            req_ack = 1; tick(); req_ack = 0;
            check("R9 ack retires", req_now(), 0);
            clear_all();
          end
    en_mem = 1; en_bus = 1; hard_active = 0; prio_mem = 8'h10; prio_bus = 8'h10;

    // R7 supervisor call and breakpoint
    for (int r = 0; r < 3; r++)
      for (int h = 0; h < 2; h++) begin
        bit take;
        take = (h == 0) && (r == 0);
        prio_svc = 8'h3F + 8'(r); hard_active = 1'(h);
        ev_svc = 1; tick(); ev_svc = 0;
        check("R7 svc forced", st_hard, take ? 0 : 2);
        check("R7 svc req", req_now(), take ? 0 : 1);
        drain(); clear_all();
      end
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 3; r++) begin
        bit take;
        take = (m == 1) && (r == 0);
        mon_en = 1'(m); prio_mon = 8'h3F + 8'(r); hard_active = 0;
        ev_bkpt = 1; tick(); ev_bkpt = 0;
        check("R7 bkpt forced", st_hard, take ? 0 : 2);
        check("R7 bkpt req", req_now(), take ? 0 : 1);
        drain(); clear_all();
      end
    mon_en = 1;

    // R5 fetch error deferral
    ev_fetch_bus = 1; tick(); ev_fetch_bus = 0;
    check("R5 pending silent st", st_bus, 0);
    check("R5 pending silent req", req_now(), 0);
    tick(); tick();
    check("R5 still silent", st_bus, 0);
    instr_exec = 1; tick(); instr_exec = 0;
    check("R5 exec status", st_bus, 2);
    check("R5 exec req", req_now(), 3);
    drain(); clear_all();
    ev_fetch_bus = 1; tick(); ev_fetch_bus = 0;
    instr_flush = 1; tick(); instr_flush = 0;
    instr_exec = 1; tick(); instr_exec = 0;
    check("R5 flushed st", st_bus, 0);
    check("R5 flushed req", req_now(), 0);
    ev_fetch_bus = 1; tick(); ev_fetch_bus = 0;
    instr_flush = 1; instr_exec = 1; tick(); instr_flush = 0; instr_exec = 0;
    check("R5 flush wins st", st_bus, 0);
    check("R5 flush wins req", req_now(), 0);
    instr_exec = 1; tick(); instr_exec = 0;
    check("R5 gone after flush", st_bus, 0);
    en_bus = 0;
    ev_fetch_bus = 1; tick(); ev_fetch_bus = 0;
    instr_exec = 1; tick(); instr_exec = 0;
    check("R5 escalated fetch st", st_bus, 2);
    check("R5 escalated fetch hard", st_hard, 2);
    check("R5 escalated fetch req", req_now(), 1);
    en_bus = 1; drain(); clear_all();

    // R8 simultaneous events drain hard, mem, bus
    ev_vec_err = 1; ev_data_mpu = 1; ev_data_bus = 1; tick();
    ev_vec_err = 0; ev_data_mpu = 0; ev_data_bus = 0;
    check("R8 st_hard", st_hard, 1);
    check("R8 st_mem", st_mem, 1);
    check("R8 st_bus", st_bus, 1);
    check("R8 first", req_now(), 1);
    req_ack = 1; tick(); req_ack = 0;
    check("R8 second", req_now(), 2);
    req_ack = 1; tick(); req_ack = 0;
    check("R8 third", req_now(), 3);
    req_ack = 1; tick(); req_ack = 0;
    check("R8 empty", req_now(), 0);
    clear_all();

    // R9 hold without ack, then a more urgent class waits its turn
    ev_inst_mpu = 1; tick(); ev_inst_mpu = 0;
    tick(); tick(); tick();
    check("R9 held", req_now(), 2);
    ev_vec_err = 1; tick(); ev_vec_err = 0;
    check("R9 not replaced", req_now(), 2);
    req_ack = 1; tick(); req_ack = 0;
    check("R9 next after ack", req_now(), 1);
    drain();

    // R10 write-one-to-clear
    check("R10 pre mem", st_mem, 2);
    clr_we = 1; clr_sel = 2'd2; clr_mask = 4'hF; tick(); clr_we = 0;
    check("R10 other field kept", st_mem, 2);
    clr_we = 1; clr_sel = 2'd3; tick(); clr_we = 0;
    check("R10 sel 3 nothing", st_mem, 2);
    ev_data_mpu = 1; ev_save_mpu = 1; tick(); ev_data_mpu = 0; ev_save_mpu = 0;
    check("R10 mem set", st_mem, 4'b1011);
    clr_we = 1; clr_sel = 2'd1; clr_mask = 4'b0011; tick(); clr_we = 0;
    check("R10 partial clear", st_mem, 4'b1000);
    clr_we = 1; clr_sel = 2'd1; clr_mask = 4'b1001; ev_data_mpu = 1; tick();
    clr_we = 0; ev_data_mpu = 0;
    check("R10 set wins", st_mem, 4'b0001);
    clr_we = 1; clr_sel = 2'd0; clr_mask = 4'b0001; tick(); clr_we = 0;
    check("R10 hard partial", st_hard, 0);
    drain(); clear_all();
    check("R10 all clear", st_mem | st_bus, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule